// File: doc/BRIEF.md
# Sample Read-Modify-Write Sequencer

This block moves one sample between memory and a pair of analog converters each time a sample strobe arrives. It reads a 20-bit word from the address held in its pointer and sends the top byte of that word to an 8-bit DAC output port. It then measures the input by counting clock steps until an external threshold detector trips. That count is placed into the low byte of the word, the word goes back to the same address, and the pointer moves on by one word.

The pointer only moves inside a 1K-word page. Its low 10 bits count up and wrap, and its upper bits never change, so a buffer plays and records in a loop until the pointer is reloaded. Bit 10 of each word asks for an interrupt when that word's sample finishes. Software can therefore place interrupts at chosen points in the buffer, usually near the end of the page.

The control is a four-state machine. IDLE waits for a strobe (IDLE→FETCH). FETCH holds a read request until it is granted (FETCH→CONVERT). CONVERT runs the step counter until the detector trips or the count saturates (CONVERT→WRITEBACK). WRITEBACK holds a write request until it is granted (WRITEBACK→IDLE). The analog ramp, the detector and any calibration table are outside the block.

Top module: `sample_rmw_engine`

## Requirements
- R1: A `sample_stb` seen in IDLE causes exactly one read and then exactly one write, both at the current pointer address. While `mem_req` is high and not granted, `mem_req`, `mem_we` and `mem_addr` stay unchanged. `mem_we` is 0 for the read and 1 for the write.
- R2: In the cycle after the read grant, `dac_out` takes bits 19..12 of the fetched word. It then holds that value until the next read grant.
- R3: `ramp_run` is high from the cycle after the read grant. If `cmp_trip` is sampled high in the k-th cycle of `ramp_run` (counting from 0), the result is k and `ramp_run` lasts k+1 cycles.
- R4: If `cmp_trip` never trips, `ramp_run` lasts 256 cycles, the result saturates at 255, and the write still takes place.
- R5: The written word keeps bits 19..8 of the fetched word unchanged, and its bits 7..0 hold the result.
- R6: After each write grant, the low 10 bits of the pointer increment modulo 1024 and bits 19..10 stay fixed. For example, 0x0FFFFF is followed by 0x0FFC00.
- R7: `irq` is a one-cycle pulse in the cycle after the write grant. It occurs if and only if bit 10 of the fetched word is 1.
- R8: A `sample_stb` that arrives outside IDLE is ignored, so no extra memory access happens. Instead `overrun` pulses for one cycle in the next cycle.
- R9: `ptr_load` in IDLE sets the pointer to `ptr_value`. `ptr_load` outside IDLE is ignored.
- R10: After reset, the block is in IDLE and `mem_req`, `ramp_run`, `irq`, `overrun` and `dac_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | Starts one sample when the block is in IDLE |
| ptr_load | input | 1 | Loads the pointer (accepted in IDLE only) |
| ptr_value | input | 20 | Value for the pointer load |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Word address |
| mem_wdata | output | 20 | Write-back word |
| mem_gnt | input | 1 | Grant; read data is valid in the grant cycle |
| mem_rdata | input | 20 | Read data |
| dac_out | output | 8 | DAC code |
| ramp_run | output | 1 | High while the conversion steps run |
| cmp_trip | input | 1 | Threshold detector output |
| irq | output | 1 | Interrupt request pulse |
| overrun | output | 1 | Pulse for a strobe that was dropped |

## Verification
A faulty state register shows up at the ports within one sample.

- **Skipped or repeated state:** the count of memory accesses per strobe is wrong, or the address changes between the read and the write.
- **Bad step counter:** the low byte of the written word and the length of `ramp_run` move away from the trip point the bench chose, and this is visible at the very next write.
- **Pointer carry fault:** it appears first at the page boundary, where a wrap that reaches the upper bits changes the next read address.
- **Wrong interrupt or overrun flag:** it is a missing or extra single-cycle pulse, one cycle after its cause.

// File: rtl/srw_pkg.sv
package srw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FETCH     = 2'd1,
        ST_CONVERT   = 2'd2,
        ST_WRITEBACK = 2'd3
    } srw_state_e;

endpackage

// File: rtl/srw_page_ptr.sv
module srw_page_ptr #(
    parameter int ADDR_W = 20,
    parameter int PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [PAGE_W-1:0] STEP = PAGE_W'(1);

    logic [ADDR_W-1:0] ptr_q;
    logic [PAGE_W-1:0] low_nxt;

    assign low_nxt = ptr_q[PAGE_W-1:0] + STEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (adv) begin
            ptr_q <= {ptr_q[ADDR_W-1:PAGE_W], low_nxt};
        end
    end

    assign ptr = ptr_q;

    // R6
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))
                        && (ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + STEP));

endmodule

// File: rtl/srw_ramp_conv.sv
module srw_ramp_conv #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             trip,
    output logic             done,
    output logic [RES_W-1:0] value
);
    localparam logic [RES_W-1:0] TOP  = '1;
    localparam logic [RES_W-1:0] INCR = RES_W'(1);

    logic [RES_W-1:0] cnt_q;

    assign done  = active && (trip || (cnt_q == TOP));
    assign value = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (active && !done) begin
            cnt_q <= cnt_q + INCR;
        end
    end

    // R3
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done && !clear) |=> (cnt_q == $past(cnt_q) + INCR));

endmodule

// File: rtl/sample_rmw_engine.sv
module sample_rmw_engine #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 20,
    parameter int PAGE_W  = 10,
    parameter int RES_W   = 8,
    parameter int DAC_LSB = 12,
    parameter int IRQ_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [RES_W-1:0]  dac_out,
    output logic              ramp_run,
    input  logic              cmp_trip,
    output logic              irq,
    output logic              overrun
);
    import srw_pkg::*;

    localparam int KEEP_W = DATA_W - RES_W;

    srw_state_e state_q, state_d;

    logic              fetch_done;
    logic              wb_done;
    logic              conv_done;
    logic [RES_W-1:0]  conv_val;
    logic [DATA_W-1:0] word_q;
    logic [RES_W-1:0]  res_q;
    logic [RES_W-1:0]  dac_q;
    logic              irq_q;
    logic              ovr_q;
    logic [ADDR_W-1:0] ptr;

    assign fetch_done = (state_q == ST_FETCH) && mem_gnt;
    assign wb_done    = (state_q == ST_WRITEBACK) && mem_gnt;

    srw_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load && (state_q == ST_IDLE)),
        .load_val (ptr_value),
        .adv      (wb_done),
        .ptr      (ptr)
    );

    srw_ramp_conv #(.RES_W(RES_W)) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (fetch_done),
        .active (state_q == ST_CONVERT),
        .trip   (cmp_trip),
        .done   (conv_done),
        .value  (conv_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (sample_stb) state_d = ST_FETCH;
            ST_FETCH:     if (mem_gnt)    state_d = ST_CONVERT;
            ST_CONVERT:   if (conv_done)  state_d = ST_WRITEBACK;
            ST_WRITEBACK: if (mem_gnt)    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            res_q  <= '0;
            dac_q  <= '0;
            irq_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (fetch_done) begin
                word_q <= mem_rdata;
                dac_q  <= mem_rdata[DAC_LSB +: RES_W];
            end
            if (conv_done) begin
                res_q <= conv_val;
            end
            irq_q <= wb_done && word_q[IRQ_BIT];
            ovr_q <= sample_stb && (state_q != ST_IDLE);
        end
    end

    always_comb begin
        mem_req  = (state_q == ST_FETCH) || (state_q == ST_WRITEBACK);
        mem_we   = (state_q == ST_WRITEBACK);
        ramp_run = (state_q == ST_CONVERT);
    end

    assign mem_addr  = ptr;
    assign mem_wdata = {word_q[DATA_W-1 -: KEEP_W], res_q};
    assign dac_out   = dac_q;
    assign irq       = irq_q;
    assign overrun   = ovr_q;

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R2
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_done |=> $stable(dac_out));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(wb_done));

    // R8
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(sample_stb && (state_q != ST_IDLE)));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT) |=> (state_q != ST_FETCH));

endmodule

// File: tb/sample_rmw_engine_test.sv
`timescale 1ns/1ps
module sample_rmw_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic        ptr_load = 1'b0;
    logic [19:0] ptr_value = '0;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [19:0] mem_rdata = '0;
    logic [7:0]  dac_out;
    logic        ramp_run;
    logic        cmp_trip = 1'b0;
    logic        irq, overrun;

    always #2 clk = ~clk;

    sample_rmw_engine uut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .ptr_load(ptr_load),
        .ptr_value(ptr_value), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .dac_out(dac_out), .ramp_run(ramp_run),
        .cmp_trip(cmp_trip), .irq(irq), .overrun(overrun)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [19:0] mem_arr [0:1023];
    int lat_cfg = 0;
    int wait_cnt = 0;
    int trip_at = 1000;
    int bstep = 0;
    int last_steps = 0;
    int rd_count = 0, wr_count = 0, irq_count = 0, ovr_count = 0;
    logic [19:0] last_rd_addr = '0, last_wr_addr = '0, last_wdata = '0;

    // memory responder, detector model and pulse monitors (negedge)
    always @(negedge clk) begin
        if (mem_gnt) begin
            mem_gnt  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat_cfg) begin
                mem_gnt <= 1'b1;
                if (mem_we) begin
                    mem_arr[mem_addr[9:0]] <= mem_wdata;
                    last_wr_addr <= mem_addr;
                    last_wdata   <= mem_wdata;
                    wr_count     <= wr_count + 1;
                end else begin
                    mem_rdata    <= mem_arr[mem_addr[9:0]];
                    last_rd_addr <= mem_addr;
                    rd_count     <= rd_count + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
        if (ramp_run) begin
            cmp_trip <= (bstep == trip_at);
            bstep    <= bstep + 1;
        end else begin
            cmp_trip <= 1'b0;
            if (bstep != 0) last_steps <= bstep;
            bstep <= 0;
        end
        if (irq)     irq_count <= irq_count + 1;
        if (overrun) ovr_count <= ovr_count + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [19:0] v);
        @(negedge clk); ptr_load = 1'b1; ptr_value = v;
        @(negedge clk); ptr_load = 1'b0;
    endtask

    task automatic pulse_stb();
        @(negedge clk); sample_stb = 1'b1;
        @(negedge clk); sample_stb = 1'b0;
    endtask

    task automatic wait_write(input int start_wr);
        for (int i = 0; i < 3000; i++) begin
            if (wr_count != start_wr) break;
            @(negedge clk);
        end
        @(negedge clk); @(negedge clk);
    endtask

    // one full sample with all per-sample checks
    task automatic run_sample(input logic [19:0] addr, input logic [19:0] word,
                              input int trip, input int lat, input string tag);
        int r0, w0, i0;
        logic [7:0] res;
        res = (trip > 255) ? 8'hFF : 8'(trip);
        mem_arr[addr[9:0]] = word;
        trip_at = trip; lat_cfg = lat;
        r0 = rd_count; w0 = wr_count; i0 = irq_count;
        pulse_stb();
        wait_write(w0);
        chk(rd_count - r0 == 1, "R1", {tag, " read count"}, rd_count - r0, 1);
        chk(wr_count - w0 == 1, "R1", {tag, " write count"}, wr_count - w0, 1);
        chk(last_rd_addr == addr, "R1", {tag, " read addr"}, last_rd_addr, addr);
        chk(last_wr_addr == addr, "R1", {tag, " write addr"}, last_wr_addr, addr);
        chk(dac_out == word[19:12], "R2", {tag, " dac"}, dac_out, word[19:12]);
        chk(last_wdata == {word[19:8], res}, "R5", {tag, " write data"},
            last_wdata, {word[19:8], res});
        chk(last_steps == int'(res) + 1, "R3", {tag, " ramp length"}, last_steps, int'(res) + 1);
        chk(irq_count - i0 == int'(word[10]), "R7", {tag, " irq pulses"},
            irq_count - i0, word[10]);
    endtask

    task automatic t_reset();
        chk(mem_req == 1'b0, "R10", "mem_req", mem_req, 0);
        chk(ramp_run == 1'b0, "R10", "ramp_run", ramp_run, 0);
        chk(irq == 1'b0, "R10", "irq", irq, 0);
        chk(overrun == 1'b0, "R10", "overrun", overrun, 0);
        chk(dac_out == 8'h00, "R10", "dac_out", dac_out, 0);
    endtask

    task automatic t_basic();
        load_ptr(20'h12340);
        run_sample(20'h12340, 20'hA5400, 37, 0, "R3 trip37");
        run_sample(20'h12341, 20'h3C0FF, 0, 3, "R3 trip0");
        run_sample(20'h12342, 20'hFF000, 200, 1, "R5 trip200");
    endtask

    task automatic t_saturate();
        // R4: detector never trips
        load_ptr(20'h00100);
        run_sample(20'h00100, 20'h7E5AA, 1000, 0, "R4 saturate");
    endtask

    task automatic t_wrap();
        // R6: 0x0FFFFF then 0x0FFC00
        load_ptr(20'h0FFFFF);
        run_sample(20'h0FFFFF, 20'h11100, 5, 0, "R6 last");
        run_sample(20'h0FFC00, 20'h22200, 6, 0, "R6 wrapped");
    endtask

    task automatic t_irq();
        // R7: bit 10 set gives one pulse, clear gives none
        load_ptr(20'h40200);
        run_sample(20'h40200, 20'h5A400, 12, 2, "R7 set");
        run_sample(20'h40201, 20'h5A000, 12, 2, "R7 clear");
    endtask

    task automatic t_overrun();
        int w0, r0, o0;
        load_ptr(20'h30010);
        mem_arr[10'h010] = 20'h81200;
        trip_at = 60; lat_cfg = 0;
        w0 = wr_count; r0 = rd_count; o0 = ovr_count;
        pulse_stb();
        repeat (8) @(negedge clk);
        pulse_stb();
        @(negedge clk);
        chk(ovr_count - o0 == 1, "R8", "overrun pulse", ovr_count - o0, 1);
        wait_write(w0);
        repeat (3) @(negedge clk);
        chk(wr_count - w0 == 1, "R8", "writes after dropped strobe", wr_count - w0, 1);
        chk(rd_count - r0 == 1, "R8", "reads after dropped strobe", rd_count - r0, 1);
    endtask

    task automatic t_load_busy();
        int w0;
        load_ptr(20'h23450);
        mem_arr[10'h050] = 20'h44400;
        trip_at = 40; lat_cfg = 0;
        w0 = wr_count;
        pulse_stb();
        repeat (6) @(negedge clk);
        load_ptr(20'h55555);
        wait_write(w0);
        run_sample(20'h23451, 20'h66600, 9, 0, "R9 load ignored");
        load_ptr(20'h07777);
        run_sample(20'h07777, 20'h12000, 3, 0, "R9 load idle");
    endtask

    task automatic t_dac_hold();
        int w0;
        load_ptr(20'h50000);
        run_sample(20'h50000, 20'hC3000, 4, 0, "R2 first");
        mem_arr[10'h001] = 20'h3C000;
        trip_at = 4; lat_cfg = 6;
        w0 = wr_count;
        pulse_stb();
        repeat (3) @(negedge clk);
        chk(mem_req && !mem_we && dac_out == 8'hC3, "R2", "dac held before grant", dac_out, 8'hC3);
        wait_write(w0);
        chk(dac_out == 8'h3C, "R2", "dac after grant", dac_out, 8'h3C);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem_arr[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_saturate();
        t_wrap();
        t_irq();
        t_overrun();
        t_load_busy();
        t_dac_hold();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule